// File: doc/BRIEF.md
# Instruction fetch and early branch resolution front end

This block is the front of a scalar in-order pipeline. It owns the program counter, drives it to a synchronous instruction memory that answers one clock later, and treats that memory's output register as the fetch-to-decode boundary. In the decode cycle it reads two source operands through an external register-file read port. In the same cycle it settles every conditional branch and jump, so the next fetch address is chosen between the sequential address and a computed target before the cycle ends.

The target adder works alongside the register read, and the equality comparator runs after it. Because of this, a taken control transfer wastes only the one sequential fetch already in flight. That instruction is marked invalid before it reaches the execute-facing register. A single stall input freezes the program counter, the memory output and both pipeline registers together.

Top module: `fetch_decode_front`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `imem_addr_o` equal to `RESET_PC` (0 by default) and `dec_valid_o` low.
- R2: On a clock edge with `stall_i` low and no taken control transfer in decode, the fetch address advances by 4 (the first address after reset release is 4).
- R3: An instruction whose address is presented in cycle t is decoded in cycle t+1 from `imem_rdata_i`. It appears on the execute-facing outputs (`dec_valid_o`, `dec_pc_o`, `dec_instr_o`) after the following non-stalled edge, in program order.
- R4: In the decode cycle, `rf_ra_o` carries instruction bits 25:21 and `rf_rb_o` carries bits 20:16. The values returned on `rf_da_i`/`rf_db_i` are forwarded as `dec_opa_o`/`dec_opb_o`.
- R5: A source index of 0 yields operand value 0 for both the forwarded operand and the branch comparison, whatever the register file returns.
- R6: The control-transfer target is the instruction's address plus 4 plus the sign-extended 16-bit field (bits 15:0) shifted left by 2. Negative offsets reach backward addresses.
- R7: Bits 31:26 select the operation: 6'h11 branches when the two operands are equal, 6'h12 branches when they differ, and 6'h13 always transfers. Any other opcode never transfers.
- R8: After a taken transfer, the next fetch address is the target. Exactly one execute-facing slot is invalid between the transfer and the target instruction.
- R9: A branch whose condition fails causes no invalid slot, and the next sequential instruction follows directly.
- R10: During a cycle with `stall_i` high, `imem_en_o` is low. The fetch address and all execute-facing outputs keep their values across the next edge.
- R11: A taken transfer sitting in decode while `stall_i` is high redirects nothing until the first non-stalled edge. It then redirects exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Freeze request for the whole front end |
| imem_addr_o | output | AW | Fetch address toward instruction memory |
| imem_en_o | output | 1 | Read enable; memory output holds while low |
| imem_rdata_i | input | 32 | Instruction returned one cycle after its address |
| rf_ra_o | output | RIDX_W | First source register index |
| rf_rb_o | output | RIDX_W | Second source register index |
| rf_da_i | input | XW | Register file data for `rf_ra_o` |
| rf_db_i | input | XW | Register file data for `rf_rb_o` |
| dec_valid_o | output | 1 | Execute-facing slot holds a real instruction |
| dec_pc_o | output | AW | Address of that instruction |
| dec_instr_o | output | 32 | Instruction word |
| dec_opa_o | output | XW | First operand |
| dec_opb_o | output | XW | Second operand |

## Verification
The two functions that collide are the stall freeze and the redirect taken by a branch resolved in decode. Both act on the program counter and on the decode valid bit on the same edge.

The bench runs a fixed program of taken and untaken branches of each kind, forward, backward and zero offsets, and a zero-register comparison. It runs the program under several stall patterns, so that stalls land on cycles where a taken branch waits in decode. The stream of execute-facing slots produced on non-stalled edges is compared with a stream the bench derives arithmetically. Any lost, doubled or early redirect shows up as a missing or extra invalid slot, or as a wrong address.

// File: rtl/fdf_pkg.sv
package fdf_pkg;

   localparam int INSTR_W = 32;
   localparam int OPC_MSB = 31;
   localparam int OPC_LSB = 26;

   localparam logic [5:0] OPC_BR_EQ  = 6'h11;
   localparam logic [5:0] OPC_BR_NE  = 6'h12;
   localparam logic [5:0] OPC_JUMP   = 6'h13;

   typedef enum logic [1:0] {
      XFER_NONE,
      XFER_EQ,
      XFER_NE,
      XFER_ALWAYS
   } xfer_kind_e;

   function automatic xfer_kind_e classify(input logic [5:0] opc);
      case (opc)
         OPC_BR_EQ: classify = XFER_EQ;
         OPC_BR_NE: classify = XFER_NE;
         OPC_JUMP:  classify = XFER_ALWAYS;
         default:   classify = XFER_NONE;
      endcase
   endfunction

endpackage

// File: rtl/fdf_pipe_reg.sv
module fdf_pipe_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic         vld_i,
   input  logic [W-1:0] dat_i,
   output logic         vld_o,
   output logic [W-1:0] dat_o
);

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_o <= 1'b0;
      end else if (en) begin
         vld_o <= vld_i;
      end
   end

   always_ff @(posedge clk) begin
      if (en) begin
         dat_o <= dat_i;
      end
   end

endmodule

// File: rtl/fdf_pc_gen.sv
module fdf_pc_gen #(
   parameter int          AW       = 32,
   parameter logic [AW-1:0] RESET_PC = '0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          advance,
   input  logic          redirect,
   input  logic [AW-1:0] target,
   output logic [AW-1:0] pc_o
);

   localparam logic [AW-1:0] STEP = AW'(4);

   logic [AW-1:0] pc_next;

   always_comb begin
      pc_next = redirect ? target : (pc_o + STEP);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_o <= RESET_PC;
      end else if (advance) begin
         pc_o <= pc_next;
      end
   end

endmodule

// File: rtl/fdf_branch_unit.sv
module fdf_branch_unit
   import fdf_pkg::*;
#(
   parameter int AW      = 32,
   parameter int XW      = 32,
   parameter int RIDX_W  = 5,
   parameter int OFF_W   = 16,
   parameter bit ZERO_R0 = 1'b1
) (
   input  logic [INSTR_W-1:0] instr,
   input  logic [AW-1:0]      pc,
   input  logic               valid,
   input  logic [XW-1:0]      rf_da,
   input  logic [XW-1:0]      rf_db,
   output logic [RIDX_W-1:0]  ra,
   output logic [RIDX_W-1:0]  rb,
   output logic [XW-1:0]      opa,
   output logic [XW-1:0]      opb,
   output logic               taken,
   output logic [AW-1:0]      target
);

   localparam int RA_LSB = 21;
   localparam int RB_LSB = 16;

   xfer_kind_e    kind;
   logic [AW-1:0] off_ext;
   logic          same;

   assign ra = instr[RA_LSB +: RIDX_W];
   assign rb = instr[RB_LSB +: RIDX_W];

   generate
      if (ZERO_R0) begin : g_zero_gate
         assign opa = (ra == '0) ? '0 : rf_da;
         assign opb = (rb == '0) ? '0 : rf_db;
      end else begin : g_pass
         assign opa = rf_da;
         assign opb = rf_db;
      end
   endgenerate

   assign off_ext = {{(AW-OFF_W){instr[OFF_W-1]}}, instr[OFF_W-1:0]};
   assign target  = pc + AW'(4) + (off_ext << 2);

   always_comb begin
      kind  = classify(instr[OPC_MSB:OPC_LSB]);
      same  = (opa == opb);
      case (kind)
         XFER_EQ:     taken = valid & same;
         XFER_NE:     taken = valid & ~same;
         XFER_ALWAYS: taken = valid;
         default:     taken = 1'b0;
      endcase
   end

endmodule

// File: rtl/fetch_decode_front.sv
module fetch_decode_front
   import fdf_pkg::*;
#(
   parameter int            AW       = 32,
   parameter int            XW       = 32,
   parameter int            RF_DEPTH = 32,
   parameter int            OFF_W    = 16,
   parameter logic [AW-1:0] RESET_PC = '0,
   parameter bit            ZERO_R0  = 1'b1,
   localparam int           RIDX_W   = $clog2(RF_DEPTH)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               stall_i,
   output logic [AW-1:0]      imem_addr_o,
   output logic               imem_en_o,
   input  logic [INSTR_W-1:0] imem_rdata_i,
   output logic [RIDX_W-1:0]  rf_ra_o,
   output logic [RIDX_W-1:0]  rf_rb_o,
   input  logic [XW-1:0]      rf_da_i,
   input  logic [XW-1:0]      rf_db_i,
   output logic               dec_valid_o,
   output logic [AW-1:0]      dec_pc_o,
   output logic [INSTR_W-1:0] dec_instr_o,
   output logic [XW-1:0]      dec_opa_o,
   output logic [XW-1:0]      dec_opb_o
);

   localparam int EX_W = AW + INSTR_W + 2 * XW;

   generate
      if (RIDX_W != 5) begin : g_bad_rf
         $error("fetch_decode_front: RF_DEPTH must give 5-bit indices");
      end
      if (OFF_W > AW || OFF_W < 2) begin : g_bad_off
         $error("fetch_decode_front: OFF_W out of range");
      end
      if (RESET_PC[1:0] != 2'b00) begin : g_bad_rst
         $error("fetch_decode_front: RESET_PC must be word aligned");
      end
   endgenerate

   logic          adv;
   logic          redir;
   logic          br_taken;
   logic [AW-1:0] br_target;
   logic [AW-1:0] pc_q;
   logic          d_valid;
   logic [AW-1:0] d_pc;
   logic [XW-1:0] opa;
   logic [XW-1:0] opb;
   logic [EX_W-1:0] ex_d;
   logic [EX_W-1:0] ex_q;

   assign adv   = ~stall_i;
   assign redir = br_taken & adv;

   fdf_pc_gen #(.AW(AW), .RESET_PC(RESET_PC)) u_pc (
      .clk      (clk),
      .rst      (rst),
      .advance  (adv),
      .redirect (redir),
      .target   (br_target),
      .pc_o     (pc_q)
   );

   assign imem_addr_o = pc_q;
   assign imem_en_o   = adv;

   fdf_pipe_reg #(.W(AW)) u_dec_reg (
      .clk   (clk),
      .rst   (rst),
      .en    (adv),
      .vld_i (~redir),
      .dat_i (pc_q),
      .vld_o (d_valid),
      .dat_o (d_pc)
   );

   fdf_branch_unit #(
      .AW(AW), .XW(XW), .RIDX_W(RIDX_W), .OFF_W(OFF_W), .ZERO_R0(ZERO_R0)
   ) u_br (
      .instr  (imem_rdata_i),
      .pc     (d_pc),
      .valid  (d_valid),
      .rf_da  (rf_da_i),
      .rf_db  (rf_db_i),
      .ra     (rf_ra_o),
      .rb     (rf_rb_o),
      .opa    (opa),
      .opb    (opb),
      .taken  (br_taken),
      .target (br_target)
   );

   assign ex_d = {d_pc, imem_rdata_i, opa, opb};

   fdf_pipe_reg #(.W(EX_W)) u_ex_reg (
      .clk   (clk),
      .rst   (rst),
      .en    (adv),
      .vld_i (d_valid),
      .dat_i (ex_d),
      .vld_o (dec_valid_o),
      .dat_o (ex_q)
   );

   assign {dec_pc_o, dec_instr_o, dec_opa_o, dec_opb_o} = ex_q;

endmodule

// File: rtl/fetch_decode_front_chk.sv
module fetch_decode_front_chk #(
   parameter int            AW       = 32,
   parameter int            XW       = 32,
   parameter logic [AW-1:0] RESET_PC = '0
) (
   input logic          clk,
   input logic          rst,
   input logic          stall_i,
   input logic [AW-1:0] imem_addr_o,
   input logic          dec_valid_o,
   input logic [31:0]   dec_instr_o,
   input logic [XW-1:0] dec_opa_o,
   input logic [XW-1:0] dec_opb_o,
   input logic          redir,
   input logic [AW-1:0] br_target,
   input logic          d_valid
);

   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (imem_addr_o == RESET_PC && !dec_valid_o));

   assert_sequential_R2: assert property (@(posedge clk) disable iff (rst)
      (!stall_i && !redir) |=> imem_addr_o == $past(imem_addr_o) + AW'(4));

   assert_zero_src_R5: assert property (@(posedge clk) disable iff (rst)
      (dec_valid_o && dec_instr_o[25:21] == 5'd0) |-> dec_opa_o == '0);

   assert_zero_srcb_R5: assert property (@(posedge clk) disable iff (rst)
      (dec_valid_o && dec_instr_o[20:16] == 5'd0) |-> dec_opb_o == '0);

   assert_redirect_target_R8: assert property (@(posedge clk) disable iff (rst)
      redir |=> imem_addr_o == $past(br_target));

   assert_one_bubble_R8: assert property (@(posedge clk) disable iff (rst)
      redir |=> !d_valid);

   assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
      stall_i |=> ($stable(imem_addr_o) && $stable(dec_valid_o)
                   && $stable(dec_instr_o)));

   assert_stall_no_redirect_R11: assert property (@(posedge clk) disable iff (rst)
      stall_i |-> !redir);

endmodule

bind fetch_decode_front fetch_decode_front_chk #(
   .AW(AW), .XW(XW), .RESET_PC(RESET_PC)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .stall_i     (stall_i),
   .imem_addr_o (imem_addr_o),
   .dec_valid_o (dec_valid_o),
   .dec_instr_o (dec_instr_o),
   .dec_opa_o   (dec_opa_o),
   .dec_opb_o   (dec_opb_o),
   .redir       (redir),
   .br_target   (br_target),
   .d_valid     (d_valid)
);

// File: tb/fetch_decode_front_test.sv
module fetch_decode_front_test;

   localparam int NEXP  = 28;
   localparam int MEMSZ = 256;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        stall_i = 1'b0;
   logic [31:0] imem_addr_o;
   logic        imem_en_o;
   logic [31:0] imem_rdata;
   logic [4:0]  rf_ra_o, rf_rb_o;
   logic [31:0] rf_da_i, rf_db_i;
   logic        dec_valid_o;
   logic [31:0] dec_pc_o, dec_instr_o, dec_opa_o, dec_opb_o;

   int tests = 0;
   int fails = 0;

   logic [31:0] mem [MEMSZ];

   logic        e_v   [NEXP];
   logic [31:0] e_pc  [NEXP];
   logic [31:0] e_ins [NEXP];
   logic [31:0] e_a   [NEXP];
   logic [31:0] e_b   [NEXP];
   string       e_tag [NEXP];

   always #5 clk = ~clk;

   fetch_decode_front uut (
      .clk(clk), .rst(rst), .stall_i(stall_i),
      .imem_addr_o(imem_addr_o), .imem_en_o(imem_en_o), .imem_rdata_i(imem_rdata),
      .rf_ra_o(rf_ra_o), .rf_rb_o(rf_rb_o), .rf_da_i(rf_da_i), .rf_db_i(rf_db_i),
      .dec_valid_o(dec_valid_o), .dec_pc_o(dec_pc_o), .dec_instr_o(dec_instr_o),
      .dec_opa_o(dec_opa_o), .dec_opb_o(dec_opb_o)
   );

   function automatic logic [31:0] rfv(input logic [4:0] i);
      rfv = 32'hA000_0000 | {28'd0, i[4:1]};
   endfunction

   function automatic logic [31:0] opnd(input logic [4:0] i);
      opnd = (i == 5'd0) ? 32'd0 : rfv(i);
   endfunction

   assign rf_da_i = rfv(rf_ra_o);
   assign rf_db_i = rfv(rf_rb_o);

   always_ff @(posedge clk) begin
      if (imem_en_o) imem_rdata <= mem[imem_addr_o[9:2]];
   end

   function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] s,
                                       input logic [4:0] t, input logic [15:0] imm);
      enc = {op, s, t, imm};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic build_program();
      for (int i = 0; i < MEMSZ; i++)
         mem[i] = enc(6'h00, 5'(i), 5'(i + 7), 16'(i));
      mem[32'h04 >> 2] = enc(6'h11, 5'd2, 5'd3, 16'd3);     // R7 eq taken -> 0x14
      mem[32'h14 >> 2] = enc(6'h12, 5'd2, 5'd3, 16'd9);     // R7 ne not taken
      mem[32'h18 >> 2] = enc(6'h11, 5'd0, 5'd1, 16'd5);     // R5 r0 vs r1 not taken
      mem[32'h1C >> 2] = enc(6'h12, 5'd4, 5'd6, 16'd2);     // ne taken -> 0x28
      mem[32'h28 >> 2] = enc(6'h13, 5'd3, 5'd5, 16'd5);     // jump -> 0x40
      mem[32'h40 >> 2] = enc(6'h11, 5'd0, 5'd0, 16'hFFFB);  // R6 backward -> 0x30
      mem[32'h30 >> 2] = enc(6'h13, 5'd0, 5'd9, 16'd19);    // jump -> 0x80
      mem[32'h80 >> 2] = enc(6'h11, 5'd8, 5'd9, 16'd0);     // taken to 0x84
   endtask

   task automatic build_expect();
      logic [31:0] pc, ins, a, b, tgt;
      bit          tk;
      int          n;
      string       nxt;
      pc = 32'd0; n = 0; nxt = "R3";
      e_v[0] = 1'b0; e_tag[0] = "R1"; n = 1;
      while (n < NEXP) begin
         ins = mem[pc[9:2]];
         a = opnd(ins[25:21]);
         b = opnd(ins[20:16]);
         e_v[n] = 1'b1; e_pc[n] = pc; e_ins[n] = ins; e_a[n] = a; e_b[n] = b;
         e_tag[n] = (ins[25:21] == 5'd0 || ins[20:16] == 5'd0) ? "R5" : nxt;
         n++;
         tgt = pc + 32'd4 + ({{16{ins[15]}}, ins[15:0]} << 2);
         case (ins[31:26])
            6'h11: tk = (a == b);
            6'h12: tk = (a != b);
            6'h13: tk = 1'b1;
            default: tk = 1'b0;
         endcase
         if (tk) begin
            if (n < NEXP) begin
               e_v[n] = 1'b0; e_tag[n] = "R8"; n++;
            end
            pc = tgt; nxt = "R6";
         end else begin
            pc = pc + 32'd4;
            nxt = (ins[31:26] == 6'h11 || ins[31:26] == 6'h12) ? "R9" : "R3";
         end
      end
   endtask

   function automatic bit stall_pat(input int mode, input int cyc);
      case (mode)
         0: stall_pat = 1'b0;
         1: stall_pat = (cyc % 3) == 1;
         2: stall_pat = (cyc % 7) == 2 || (cyc % 7) == 3;
         default: stall_pat = ((cyc * 5) % 11) < 4;
      endcase
   endfunction

   task automatic run_pass(input int mode);
      int          idx;
      logic [31:0] p_addr, p_ins, p_pc;
      logic        p_v;
      bit          ok;
      rst = 1'b1; stall_i = 1'b0;
      repeat (3) @(negedge clk);
      check(imem_addr_o == 32'd0 && dec_valid_o == 1'b0, "R1 reset state",
            {dec_valid_o, imem_addr_o[30:0]}, 32'd0);
      rst = 1'b0;
      idx = 0;
      for (int cyc = 0; cyc < 400 && idx < NEXP; cyc++) begin
         stall_i = stall_pat(mode, cyc);
         #1;
         p_addr = imem_addr_o; p_ins = dec_instr_o; p_pc = dec_pc_o; p_v = dec_valid_o;
         if (stall_i) begin
            check(imem_en_o == 1'b0, "R10 enable low in stall", 32'(imem_en_o), 32'd0);
         end else if (idx > 0) begin
            check(rf_ra_o == imem_rdata[25:21] && rf_rb_o == imem_rdata[20:16],
                  "R4 index routing", {22'd0, rf_ra_o, rf_rb_o},
                  {22'd0, imem_rdata[25:21], imem_rdata[20:16]});
         end
         @(negedge clk);
         if (stall_i) begin
            check(imem_addr_o == p_addr && dec_valid_o == p_v && dec_instr_o == p_ins
                  && dec_pc_o == p_pc, "R10 R11 hold under stall", imem_addr_o, p_addr);
         end else begin
            if (idx == 0)
               check(imem_addr_o == 32'd4, "R2 first step", imem_addr_o, 32'd4);
            if (e_v[idx])
               ok = dec_valid_o && dec_pc_o == e_pc[idx] && dec_instr_o == e_ins[idx]
                    && dec_opa_o == e_a[idx] && dec_opb_o == e_b[idx];
            else
               ok = !dec_valid_o;
            check(ok, $sformatf("%s R7 slot %0d mode %0d", e_tag[idx], idx, mode),
                  dec_valid_o ? dec_pc_o : 32'hFFFF_FFFF,
                  e_v[idx] ? e_pc[idx] : 32'hFFFF_FFFF);
            idx++;
         end
      end
      check(idx == NEXP, "R3 stream complete", 32'(idx), 32'(NEXP));
   endtask

   initial begin
      build_program();
      build_expect();
      for (int m = 0; m < 4; m++) run_pass(m);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #2000000;
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule